// File: doc/BRIEF.md
# Programmable Interval Tick Timer

This block is a per-core interval timer built around a free-running tick counter and a single control word. The counter advances once for every cycle in which the tick-enable input is high, provided the timer is armed. The control word holds four things: a two-bit mode, an interrupt-enable bit, a sticky interrupt-pending bit and a period field. A timer event fires when an advancing count lands on a value whose low period bits equal the period field. The mode then decides what the event does to the counter. It can clear the counter to zero, stop it where it is, or let it keep counting.

Software reaches the counter and the control word through a plain register port. A write takes effect at the clock edge. A read is combinational on the selected register. The port carries no stream data, so it has no valid/ready handshake and never back-pressures. A write is accepted in any cycle in which `reg_wr` is high. The interrupt output is a level signal that stays high while an event is pending and interrupts are enabled.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, `irq` is low, and ticks do not advance the counter until a non-zero mode is written.
- R2: While armed, the counter rises by exactly one at each clock edge where `tick_en` is high, and it holds its value in cycles where `tick_en` is low.
- R3: Mode 2'b00 (off) is written in control bits [31:30]. In this mode the counter holds its value whatever `tick_en` does.
- R4: An event fires on the tick that brings counter bits [27:0] equal to control bits [27:0], regardless of the upper counter bits. If the masked count is already at or beyond the period, the next event comes only after bits [27:0] wrap through zero.
- R5: Control bit 29 is the interrupt enable. On an event with it set, pending bit 28 becomes 1 and `irq` is high in the cycle after the event edge. On an event with it clear, the pending bit stays 0.
- R6: In mode 2'b01 (restart), the event edge loads the counter with 0, and counting carries on from there.
- R7: In mode 2'b10 (one-shot), the event edge leaves the counter at the period value and disarms it, so further ticks change nothing. Writing a non-zero mode re-arms counting.
- R8: In mode 2'b11 (continuous), the event leaves the count untouched, and it keeps rising past the match.
- R9: The pending bit is sticky. Writing a 1 to it keeps it, and writing a 0 clears it. `irq` is high only while both the pending bit and the enable bit are 1.
- R10: A write with `reg_sel`=0 loads the counter, and the new value reads back from the next cycle. The write wins over a tick in the same cycle.
- R11: `reg_rdata` shows the counter when `reg_sel`=0 and the control word when `reg_sel`=1, laid out as {mode[31:30], enable[29], pending[28], period[27:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count one tick this cycle |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | 0 selects the counter, 1 selects the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The assertions assume that every input is synchronous to `clk` and free of X once reset is released. They only constrain counter motion in cycles with no register write, because a write overrides both ticks and events. The stimulus changes inputs just after the rising edge and holds `tick_en` low during control-word writes. It also avoids writes in cycles where an event is due, so each mode's event action is seen in isolation.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tmode_e;

  typedef struct packed {
    tmode_e mode;
    logic   ie;
    logic   ip;
  } tctl_t;

  localparam int CTL_FLAG_W = 4;

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              clear,
  input  logic              adv,
  output logic [WORD_W-1:0] cnt
);

  logic [WORD_W-1:0] cnt_q;

  // priority: software load, then event clear, then advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (clear)  cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tick_match.sv
module tick_match #(
  parameter int WORD_W = 32,
  parameter int PER_W  = 28
) (
  input  logic [WORD_W-1:0] cnt,
  input  logic [PER_W-1:0]  period,
  input  logic              adv,
  output logic              evt
);

  logic [PER_W-1:0] next_low;

  // compare the value the count is about to take, so a held count never re-fires
  assign next_low = cnt[PER_W-1:0] + PER_W'(1);
  assign evt      = adv && (next_low == period);

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [PER_W+CTL_FLAG_W-1:0] wdata,
  input  logic                       evt,
  output tmode_e                     mode,
  output logic                       ie,
  output logic                       ip,
  output logic [PER_W-1:0]           period,
  output logic                       run
);

  tctl_t            ctl_q;
  logic [PER_W-1:0] per_q;
  logic             run_q;
  tctl_t            ctl_w;

  assign ctl_w = tctl_t'(wdata[PER_W+CTL_FLAG_W-1:PER_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{mode: TM_OFF, ie: 1'b0, ip: 1'b0};
      per_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr) begin
        ctl_q.mode <= ctl_w.mode;
        ctl_q.ie   <= ctl_w.ie;
        per_q      <= wdata[PER_W-1:0];
        run_q      <= (ctl_w.mode != TM_OFF);
      end else if (evt && ctl_q.mode == TM_ONESHOT) begin
        run_q <= 1'b0;
      end
      // pending: a new event sets it, a written zero clears it, a written one keeps it
      ctl_q.ip <= (evt && ctl_q.ie) || (ctl_q.ip && !(wr && !ctl_w.ip));
    end
  end

  assign mode   = ctl_q.mode;
  assign ie     = ctl_q.ie;
  assign ip     = ctl_q.ip;
  assign period = per_q;
  assign run    = run_q && (ctl_q.mode != TM_OFF);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PER_W  = 28,
  localparam int WORD_W = PER_W + CTL_FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);

  logic [WORD_W-1:0] cnt_q;
  logic [PER_W-1:0]  period;
  tmode_e            mode;
  logic              ie, ip, run, evt, adv, cnt_wr, ctl_wr, clr;

  assign cnt_wr = reg_wr && !reg_sel;
  assign ctl_wr = reg_wr &&  reg_sel;
  assign adv    = tick_en && run && !cnt_wr;
  assign clr    = evt && (mode == TM_RESTART);

  tick_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(reg_wdata), .evt(evt),
    .mode(mode), .ie(ie), .ip(ip), .period(period), .run(run)
  );

  tick_match #(.WORD_W(WORD_W), .PER_W(PER_W)) u_match (
    .cnt(cnt_q), .period(period), .adv(adv), .evt(evt)
  );

  tick_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(reg_wdata),
    .clear(clr), .adv(adv), .cnt(cnt_q)
  );

  assign reg_rdata = reg_sel ? {mode, ie, ip, period} : cnt_q;
  assign irq       = ip && ie;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              reg_wr,
  input logic [WORD_W-1:0] cnt,
  input tmode_e            mode,
  input logic              ie,
  input logic              ip,
  input logic              run,
  input logic              evt,
  input logic              irq
);

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (cnt == '0 && !irq));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !reg_wr) |=> $stable(cnt));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && run && !reg_wr && !evt) |=> cnt == WORD_W'($past(cnt) + 1'b1));

  p_off_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_OFF && !reg_wr) |=> $stable(cnt));

  p_pending_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ie) |=> ip);

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode == TM_RESTART && !reg_wr) |=> cnt == '0);

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode == TM_ONESHOT && !reg_wr) |=> !run);

  p_pending_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ip && !reg_wr) |=> ip);

endmodule

bind tick_timer tick_timer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr), .cnt(cnt_q),
  .mode(mode), .ie(ie), .ip(ip), .run(run), .evt(evt), .irq(irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  typedef struct {
    bit          is_irq;
    bit          sel;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  sb_item_t sbq[$];

  always #5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h exp %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(input bit sel, input logic [31:0] exp, input string tag);
    sb_item_t it;
    reg_sel = sel;
    it = '{is_irq: 1'b0, sel: sel, exp: exp, tag: tag};
    sbq.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_irq(input bit exp, input string tag);
    sb_item_t it;
    it = '{is_irq: 1'b1, sel: 1'b0, exp: {31'b0, exp}, tag: tag};
    sbq.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) step();
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_rd(0, 32'h0, "R1 counter after reset");
    expect_rd(1, 32'h0, "R1 control after reset");
    expect_irq(1'b0, "R1 irq after reset");
    step();
    ticks(5);
    expect_rd(0, 32'h0, "R3 off mode holds after reset");

    wr(1, 32'hC000_0064);
    step();
    ticks(5);
    expect_rd(0, 32'h5, "R2 five ticks");
    step(); step(); step();
    expect_rd(0, 32'h5, "R2 no tick holds");

    wr(0, 32'h1234_0010);
    expect_rd(0, 32'h1234_0010, "R10 counter load");
    tick_en = 1'b1;
    wr(0, 32'h0000_0050);
    tick_en = 1'b0;
    expect_rd(0, 32'h0000_0050, "R10 write beats tick");

    wr(1, 32'hE000_0060);
    step();
    ticks(16);
    expect_rd(0, 32'h60, "R8 count at match");
    expect_irq(1'b1, "R5 irq after event");
    expect_rd(1, 32'hF000_0060, "R11 control readback with pending");
    step();
    ticks(2);
    expect_rd(0, 32'h62, "R8 continues past match");

    wr(1, 32'hF000_0060);
    expect_rd(1, 32'hF000_0060, "R9 write one keeps pending");
    wr(1, 32'hD000_0060);
    expect_irq(1'b0, "R9 irq masked by enable");
    expect_rd(1, 32'hD000_0060, "R9 pending survives mask");
    wr(1, 32'hC000_0060);
    expect_rd(1, 32'hC000_0060, "R9 write zero clears pending");
    wr(1, 32'hE000_0060);
    expect_irq(1'b0, "R9 no irq without pending");

    wr(0, 32'h0FFF_FFF0);
    wr(1, 32'hE000_0005);
    step();
    ticks(16);
    expect_rd(0, 32'h1000_0000, "R4 wrapped without event");
    expect_irq(1'b0, "R4 no event past period");
    step();
    ticks(5);
    expect_irq(1'b1, "R4 event after wrap on masked bits");
    wr(1, 32'hC000_0005);

    wr(0, 32'h0);
    wr(1, 32'h6000_0004);
    step();
    ticks(3);
    expect_rd(0, 32'h3, "R6 before match");
    expect_irq(1'b0, "R6 no early event");
    step();
    ticks(1);
    expect_rd(0, 32'h0, "R6 cleared at match");
    expect_irq(1'b1, "R5 irq on restart event");
    step();
    ticks(2);
    expect_rd(0, 32'h2, "R6 counting resumes");
    wr(1, 32'h4000_0004);
    step();
    ticks(2);
    expect_rd(0, 32'h0, "R6 second restart");
    expect_irq(1'b0, "R5 no pending without enable");
    expect_rd(1, 32'h4000_0004, "R5 pending stays clear");

    wr(0, 32'h0);
    wr(1, 32'h8000_0003);
    step();
    ticks(3);
    expect_rd(0, 32'h3, "R7 stops at period");
    step();
    ticks(4);
    expect_rd(0, 32'h3, "R7 stays stopped");
    wr(1, 32'h8000_0003);
    step();
    ticks(2);
    expect_rd(0, 32'h5, "R7 rearmed by write");

    wr(1, 32'h0000_0003);
    step();
    ticks(4);
    expect_rd(0, 32'h5, "R3 off mode holds");
    expect_rd(1, 32'h0000_0003, "R11 control readback");

    step(); step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule